// File: doc/BRIEF.md
# SPI Chip Select Sequencer

This block owns the four chip-select lines of an SPI host. Each transfer is identified by a 4-bit peripheral code. In fixed mode the code comes from a configuration field, and in variable mode it arrives with each start request. The code is turned into line levels in one of two ways. The direct scheme selects one line by priority on the lowest-order zero bit of the code. The decode scheme puts the code itself on the lines, so that an external 4-to-16 decoder can address up to 15 devices. An inversion control flips all four lines from active low to active high.

Between releasing one select and asserting the next, the block inserts a non-overlap gap. The gap is counted in ticks of a clock-enable input, so it can follow a slower bit-rate clock, or plain clock cycles when the enable is tied high. A start that arrives during the gap is held until the gap has run out. A single-cycle done pulse marks the moment a line is asserted, and an end request releases the line. Configuration is written through a register port, and writes are dropped while a lock input is high.

Top module: `spi_select_sequencer`

## Requirements
- R1: After reset all four lines sit at their inactive level and done and error are low. The first select after reset is also preceded by the full minimum gap: with the tick held high and a start presented on the first cycle out of reset, done appears on the eighth sampled cycle after reset ends.
- R2: With the decode scheme off (config bit 13 = 0) and polarity normal, the asserted line is the lowest-order zero bit of the code. Codes xxx0, xx01, x011 and 0111 give lines 1110, 1101, 1011 and 0111. Exactly one line is low while a select is active.
- R3: Code 1111 is illegal. It asserts no line, gives no done pulse, and gives a one-cycle error pulse instead.
- R4: With the decode scheme on (config bit 13 = 1), the lines carry the code value itself, bit for bit.
- R5: The group output is the timing group of the selected device. In decode mode it is code bits 3:2, so devices 0–3 map to 0, 4–7 to 1, 8–11 to 2 and 12–14 to 3. In direct mode it is the index of the asserted line.
- R6: With config bit 14 = 1, all four lines are inverted, both while idle (0000) and while a select is active.
- R7: After a line is released, the next one is not asserted until max(gap field, 6) ticks have been counted; the gap field is config bits 7:0. With the tick held high, the lines stay inactive for gap+2 sampled cycles between the end request and the next done.
- R8: In fixed mode (config bit 12 = 0) the code is config bits 11:8 and the request code is ignored. In variable mode (config bit 12 = 1) the request code is used. The code is latched when the request is taken.
- R9: A configuration write made while the lock input is high leaves the configuration unchanged.
- R10: A start that arrives during the gap is held and served once the gap ends. A start that arrives while a select is active is dropped. Done lasts exactly one cycle.
- R11: An end request while a select is active returns all lines to inactive on the next clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_lock | input | 1 | Write protection; a write is dropped while this is high |
| cfg_wdata | input | 15 | Configuration: [14] invert, [13] decode, [12] variable, [11:8] fixed code, [7:0] gap |
| tick | input | 1 | Clock enable for the gap counter |
| req_start | input | 1 | Transfer start request |
| req_code | input | 4 | Peripheral code used in variable mode |
| req_end | input | 1 | Transfer end; releases the active select |
| sel_lines | output | 4 | Chip-select line levels |
| sel_done | output | 1 | One-cycle pulse when a select is asserted |
| sel_err | output | 1 | One-cycle pulse when an illegal code is taken |
| sel_group | output | 2 | Timing group of the current device |

## Verification
The bench probes several corner cases, each tied to a specific failure:
- Priority patterns whose upper bits are noise, such as 1010 and 0101. A decoder that reads the code as a binary index would pick the wrong line.
- Code 1111 in both schemes. A design without the illegal-code guard would either drive 1111 as a valid decode address or assert no line while still pulsing done.
- Gap length at small, large and below-floor field values, with both a continuous and a divided tick. An off-by-one gap, a missing floor of six, or a counter that ignores the enable would shift the done pulse.
- A start during the gap with its code changed before service, a start during an active select, and a write made while the lock is high. These catch a design that samples the code late, queues the dropped start, or lets a locked write through.

// File: rtl/spi_sel_pkg.sv
package spi_sel_pkg;

    localparam int SEL_W   = 4;
    localparam int CODE_W  = SEL_W;
    localparam int GRP_W   = $clog2(SEL_W);
    localparam int GAP_W   = 8;
    localparam int MIN_GAP = 6;

    typedef logic [CODE_W-1:0] code_t;

    typedef struct packed {
        logic             inv_mode;
        logic             dec_mode;
        logic             var_mode;
        code_t            fixed_code;
        logic [GAP_W-1:0] gap;
    } cfg_t;

    localparam int CFG_W = $bits(cfg_t);

    typedef enum logic [1:0] {
        ST_GAP,
        ST_IDLE,
        ST_ACTIVE
    } phase_e;

    function automatic logic code_illegal(input code_t c);
        return &c;
    endfunction

endpackage

// File: rtl/sel_cfg_reg.sv
module sel_cfg_reg
    import spi_sel_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic we,
    input  logic lock,
    input  cfg_t wdata,
    output cfg_t cfg_q
);

    always_ff @(posedge clk) begin
        if (rst) begin
            cfg_q <= '0;
        end else if (we && !lock) begin
            cfg_q <= wdata;
        end
    end

endmodule

// File: rtl/sel_gap_timer.sv
module sel_gap_timer #(
    parameter int W   = 8,
    parameter int MIN = 6
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         clear,
    input  logic         tick,
    input  logic [W-1:0] limit,
    output logic         expired
);

    localparam logic [W-1:0] FLOOR = W'(MIN);

    logic [W-1:0] cnt_q;
    logic [W-1:0] span;

    assign span    = (limit < FLOOR) ? FLOOR : limit;
    assign expired = (cnt_q >= span);

    always_ff @(posedge clk) begin
        if (rst || clear) begin
            cnt_q <= '0;
        end else if (tick && !expired) begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

endmodule

// File: rtl/sel_line_encoder.sv
module sel_line_encoder
    import spi_sel_pkg::*;
(
    input  code_t              code,
    input  logic               dec_mode,
    output logic [SEL_W-1:0]   lines,
    output logic [GRP_W-1:0]   group
);

    logic [SEL_W-1:0] hit;
    logic [GRP_W-1:0] hit_idx;

    generate
        for (genvar i = 0; i < SEL_W; i++) begin : g_hit
            if (i == 0) begin : g_first
                assign hit[i] = ~code[0];
            end else begin : g_rest
                assign hit[i] = ~code[i] & (&code[i-1:0]);
            end
        end
    endgenerate

    always_comb begin
        hit_idx = '0;
        for (int i = 0; i < SEL_W; i++) begin
            if (hit[i]) hit_idx = GRP_W'(i);
        end
    end

    assign lines = dec_mode ? code : ~hit;
    assign group = dec_mode ? code[CODE_W-1 -: GRP_W] : hit_idx;

endmodule

// File: rtl/spi_select_sequencer.sv
module spi_select_sequencer
    import spi_sel_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             cfg_we,
    input  logic             cfg_lock,
    input  logic [CFG_W-1:0] cfg_wdata,
    input  logic             tick,
    input  logic             req_start,
    input  logic [CODE_W-1:0] req_code,
    input  logic             req_end,
    output logic [SEL_W-1:0] sel_lines,
    output logic             sel_done,
    output logic             sel_err,
    output logic [GRP_W-1:0] sel_group
);

    cfg_t             cfg_q;
    phase_e           state_q;
    logic             pend_q;
    code_t            pcode_q;
    logic [SEL_W-1:0] raw_q;
    logic [GRP_W-1:0] grp_q;
    logic             done_q;
    logic             err_q;
    logic             gap_expired;

    code_t            new_code;
    code_t            take_code;
    logic [SEL_W-1:0] enc_lines;
    logic [GRP_W-1:0] enc_group;

    sel_cfg_reg i_cfg (
        .clk   (clk),
        .rst   (rst),
        .we    (cfg_we),
        .lock  (cfg_lock),
        .wdata (cfg_t'(cfg_wdata)),
        .cfg_q (cfg_q)
    );

    sel_gap_timer #(
        .W   (GAP_W),
        .MIN (MIN_GAP)
    ) i_gap (
        .clk     (clk),
        .rst     (rst),
        .clear   (state_q != ST_GAP),
        .tick    (tick),
        .limit   (cfg_q.gap),
        .expired (gap_expired)
    );

    assign new_code  = cfg_q.var_mode ? req_code : cfg_q.fixed_code;
    assign take_code = pend_q ? pcode_q : new_code;

    sel_line_encoder i_enc (
        .code     (take_code),
        .dec_mode (cfg_q.dec_mode),
        .lines    (enc_lines),
        .group    (enc_group)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= ST_GAP;
            pend_q  <= 1'b0;
            pcode_q <= '0;
            raw_q   <= '1;
            grp_q   <= '0;
            done_q  <= 1'b0;
            err_q   <= 1'b0;
        end else begin
            done_q <= 1'b0;
            err_q  <= 1'b0;
            unique case (state_q)
                ST_GAP: begin
                    if (req_start && !pend_q) begin
                        pend_q  <= 1'b1;
                        pcode_q <= new_code;
                    end
                    if (gap_expired) state_q <= ST_IDLE;
                end
                ST_IDLE: begin
                    if (pend_q || req_start) begin
                        pend_q <= 1'b0;
                        if (code_illegal(take_code)) begin
                            err_q <= 1'b1;
                        end else begin
                            state_q <= ST_ACTIVE;
                            raw_q   <= enc_lines;
                            grp_q   <= enc_group;
                            done_q  <= 1'b1;
                        end
                    end
                end
                ST_ACTIVE: begin
                    if (req_end) begin
                        raw_q   <= '1;
                        state_q <= ST_GAP;
                    end
                end
                default: state_q <= ST_GAP;
            endcase
        end
    end

    assign sel_lines = raw_q ^ {SEL_W{cfg_q.inv_mode}};
    assign sel_done  = done_q;
    assign sel_err   = err_q;
    assign sel_group = grp_q;

endmodule

// File: rtl/spi_select_sequencer_chk.sv
module spi_select_sequencer_chk
    import spi_sel_pkg::*;
(
    input logic             clk,
    input logic             rst,
    input logic             cfg_we,
    input logic             cfg_lock,
    input logic             req_end,
    input cfg_t             cfg_q,
    input logic [SEL_W-1:0] raw_q,
    input logic             sel_done,
    input logic             sel_err
);

    logic [GAP_W-1:0] quiet_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            quiet_q <= '0;
        end else if (raw_q != '1) begin
            quiet_q <= '0;
        end else if (quiet_q != '1) begin
            quiet_q <= quiet_q + 1'b1;
        end
    end

    // R1
    reset_idle_chk: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (raw_q == '1 && !sel_done && !sel_err));

    // R2
    one_line_chk: assert property (@(posedge clk) disable iff (rst)
        (sel_done && !$past(cfg_q.dec_mode)) |-> ($countones(~raw_q) == 1));

    // R3
    illegal_quiet_chk: assert property (@(posedge clk) disable iff (rst)
        sel_err |-> (raw_q == '1 && !sel_done));

    // R7
    gap_min_chk: assert property (@(posedge clk) disable iff (rst)
        sel_done |-> (quiet_q >= GAP_W'(MIN_GAP)));

    // R9
    lock_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (cfg_we && cfg_lock) |=> $stable(cfg_q));

    // R11
    release_chk: assert property (@(posedge clk) disable iff (rst)
        (req_end && raw_q != '1) |=> (raw_q == '1));

endmodule

bind spi_select_sequencer spi_select_sequencer_chk i_chk (
    .clk      (clk),
    .rst      (rst),
    .cfg_we   (cfg_we),
    .cfg_lock (cfg_lock),
    .req_end  (req_end),
    .cfg_q    (cfg_q),
    .raw_q    (raw_q),
    .sel_done (sel_done),
    .sel_err  (sel_err)
);

// File: tb/test_spi_select_sequencer.sv
module test_spi_select_sequencer;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        cfg_we = 1'b0;
    logic        cfg_lock = 1'b0;
    logic [14:0] cfg_wdata = '0;
    logic        tick = 1'b1;
    logic        req_start = 1'b0;
    logic [3:0]  req_code = '0;
    logic        req_end = 1'b0;
    logic [3:0]  sel_lines;
    logic        sel_done;
    logic        sel_err;
    logic [1:0]  sel_group;

    always #5 clk = ~clk;

    spi_select_sequencer i_spi_select_sequencer (
        .clk       (clk),
        .rst       (rst),
        .cfg_we    (cfg_we),
        .cfg_lock  (cfg_lock),
        .cfg_wdata (cfg_wdata),
        .tick      (tick),
        .req_start (req_start),
        .req_code  (req_code),
        .req_end   (req_end),
        .sel_lines (sel_lines),
        .sel_done  (sel_done),
        .sel_err   (sel_err),
        .sel_group (sel_group)
    );

    int    total = 0;
    int    bad = 0;
    int    cyc = 0;
    bit    finished = 0;
    bit    started = 0;
    bit    tick_slow = 0;
    int    tick_div = 0;
    string cur_req = "R1";

    // behavioural reference state
    int         m_phase;
    int         m_cnt;
    int         m_eff;
    bit         m_pend;
    logic [3:0] m_pcode;
    logic [3:0] m_raw;
    logic [1:0] m_grp;
    bit         m_done;
    bit         m_err;
    logic [7:0] m_gap;
    logic [3:0] m_fix;
    bit         m_var, m_dec, m_inv;
    logic [3:0] m_c;
    logic [5:0] m_sel;

    task automatic chk(input string req, input string what, input logic [7:0] act, input logic [7:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s %s act=%0h exp=%0h t=%0t", req, what, act, exp, $time);
        end
    endtask

    function automatic logic [5:0] ref_select(input logic [3:0] c, input bit dec);
        int idx;
        if (dec) return {c[3:2], c};
        idx = 0;
        for (int b = 3; b >= 0; b--) if (!c[b]) idx = b;
        return {2'(idx), ~(4'b0001 << idx)};
    endfunction

    always @(posedge clk) begin
        started = 1;
        if (rst) begin
            m_phase = 0; m_cnt = 0; m_pend = 0; m_pcode = 0;
            m_raw = 4'hF; m_grp = 0; m_done = 0; m_err = 0;
            m_gap = 0; m_fix = 0; m_var = 0; m_dec = 0; m_inv = 0;
        end else begin
            m_done = 0;
            m_err  = 0;
            m_eff  = (m_gap < 6) ? 6 : int'(m_gap);
            case (m_phase)
                0: begin
                    if (req_start && !m_pend) begin
                        m_pend  = 1;
                        m_pcode = m_var ? req_code : m_fix;
                    end
                    if (m_cnt >= m_eff) m_phase = 1;
                    else if (tick) m_cnt++;
                end
                1: begin
                    if (m_pend || req_start) begin
                        m_c    = m_pend ? m_pcode : (m_var ? req_code : m_fix);
                        m_pend = 0;
                        if (m_c == 4'hF) begin
                            m_err = 1;
                        end else begin
                            m_sel   = ref_select(m_c, m_dec);
                            m_raw   = m_sel[3:0];
                            m_grp   = m_sel[5:4];
                            m_done  = 1;
                            m_phase = 2;
                        end
                    end
                end
                default: begin
                    if (req_end) begin
                        m_raw = 4'hF; m_phase = 0; m_cnt = 0;
                    end
                end
            endcase
            if (cfg_we && !cfg_lock) {m_inv, m_dec, m_var, m_fix, m_gap} = cfg_wdata;
        end
    end

    // every-clock comparison against the reference
    always @(negedge clk) begin
        if (started && !finished) begin
            chk(cur_req, "lines", {4'h0, sel_lines}, {4'h0, m_raw ^ {4{m_inv}}});
            chk(cur_req, "done", {7'h0, sel_done}, {7'h0, m_done});
            chk(cur_req, "err", {7'h0, sel_err}, {7'h0, m_err});
            chk(cur_req, "group", {6'h0, sel_group}, {6'h0, m_grp});
        end
        if (tick_slow) begin
            tick_div = (tick_div + 1) % 3;
            tick = (tick_div == 0);
        end else begin
            tick = 1'b1;
        end
    end

    task automatic report;
        if (!finished) begin
            finished = 1;
            $display("test done: total=%0d bad=%0d", total, bad);
        end
    endtask

    always @(posedge clk) begin
        cyc++;
        if (cyc == 100000 && !finished) begin
            total++;
            bad++;
            $display("FAIL watchdog %s act=hung exp=finished", cur_req);
            report();
            $finish;
        end
    end

    task automatic cfgw(input logic [7:0] gap, input logic [3:0] fix, input bit vm, input bit dm,
                        input bit im, input bit lock);
        @(negedge clk);
        cfg_we = 1; cfg_lock = lock; cfg_wdata = {im, dm, vm, fix, gap};
        @(negedge clk);
        cfg_we = 0; cfg_lock = 0;
    endtask

    task automatic wait_event;
        int n = 0;
        while (!sel_done && !sel_err && n < 300) begin
            @(negedge clk);
            n++;
        end
    endtask

    task automatic release_sel(input string req);
        @(negedge clk); req_end = 1;
        @(negedge clk); req_end = 0;
        chk(req, "released", {4'h0, sel_lines}, {4'h0, {4{m_inv}} ^ 4'hF});
    endtask

    task automatic xfer(input logic [3:0] code, input bit exp_err, input logic [3:0] exp_lines,
                        input logic [1:0] exp_grp, input string req);
        cur_req = req;
        @(negedge clk); req_start = 1; req_code = code;
        @(negedge clk); req_start = 0;
        wait_event();
        chk(req, "err taken", {7'h0, sel_err}, {7'h0, exp_err});
        chk(req, "lines taken", {4'h0, sel_lines}, {4'h0, exp_lines});
        if (!exp_err) chk(req, "group taken", {6'h0, sel_group}, {6'h0, exp_grp});
        release_sel("R11");
    endtask

    task automatic measure_gap(input int exp_q, input bit exact, input string req);
        int q;
        cur_req = req;
        @(negedge clk); req_start = 1; req_code = 4'h0;
        @(negedge clk); req_start = 0;
        wait_event();
        @(negedge clk); req_end = 1;
        @(negedge clk); req_end = 0; req_start = 1; req_code = 4'h0;
        q = 1;
        @(negedge clk); req_start = 0;
        while (!sel_done && q < 2000) begin
            q++;
            @(negedge clk);
        end
        if (exact) chk(req, "gap cycles", 8'(q), 8'(exp_q));
        else chk(req, "gap at least", {7'h0, (q >= exp_q)}, 8'h1);
        release_sel("R11");
    endtask

    initial begin
        int q;
        int dn;
        repeat (3) @(negedge clk);
        // R1: reset state
        chk("R1", "reset lines", {4'h0, sel_lines}, 8'h0F);
        chk("R1", "reset done", {7'h0, sel_done}, 8'h0);
        chk("R1", "reset err", {7'h0, sel_err}, 8'h0);
        // R1: first select after reset waits for the gap
        rst = 0; req_start = 1; req_code = 4'h0;
        q = 1;
        @(negedge clk); req_start = 0;
        while (!sel_done && q < 100) begin
            q++;
            @(negedge clk);
        end
        chk("R1", "first gap", 8'(q), 8'd8);
        chk("R2", "fixed code 0", {4'h0, sel_lines}, 8'h0E);
        @(negedge clk);
        chk("R10", "done one cycle", {7'h0, sel_done}, 8'h0);
        release_sel("R11");

        // R2 / R8 variable mode, direct priority
        cfgw(8'd0, 4'h0, 1, 0, 0, 0);
        xfer(4'b1010, 0, 4'hE, 2'd0, "R2");
        xfer(4'b0101, 0, 4'hD, 2'd1, "R2");
        xfer(4'b1011, 0, 4'hB, 2'd2, "R2");
        xfer(4'b0111, 0, 4'h7, 2'd3, "R2");
        xfer(4'b0000, 0, 4'hE, 2'd0, "R8");
        // R3 illegal code, direct
        xfer(4'hF, 1, 4'hF, 2'd0, "R3");

        // R4 / R5 decode scheme
        cfgw(8'd0, 4'h0, 1, 1, 0, 0);
        xfer(4'd5, 0, 4'd5, 2'd1, "R4");
        xfer(4'd9, 0, 4'd9, 2'd2, "R5");
        xfer(4'd14, 0, 4'd14, 2'd3, "R5");
        xfer(4'd2, 0, 4'd2, 2'd0, "R4");
        xfer(4'hF, 1, 4'hF, 2'd0, "R3");

        // R6 inversion
        cfgw(8'd0, 4'h0, 1, 0, 1, 0);
        @(negedge clk);
        chk("R6", "idle inverted", {4'h0, sel_lines}, 8'h00);
        xfer(4'b0001, 0, 4'h2, 2'd1, "R6");
        cfgw(8'd0, 4'h0, 1, 1, 1, 0);
        xfer(4'd6, 0, 4'h9, 2'd1, "R6");

        // R8 fixed mode ignores the request code
        cfgw(8'd0, 4'b0111, 0, 0, 0, 0);
        xfer(4'b0000, 0, 4'h7, 2'd3, "R8");
        // R9 locked write dropped
        cfgw(8'd0, 4'b0011, 1, 1, 1, 1);
        xfer(4'b0000, 0, 4'h7, 2'd3, "R9");
        cfgw(8'd0, 4'b1101, 0, 0, 0, 0);
        xfer(4'b0000, 0, 4'hD, 2'd1, "R8");

        // R7 gap lengths
        cfgw(8'd20, 4'h0, 1, 0, 0, 0);
        measure_gap(22, 1, "R7");
        cfgw(8'd3, 4'h0, 1, 0, 0, 0);
        measure_gap(8, 1, "R7");
        cfgw(8'd6, 4'h0, 1, 0, 0, 0);
        tick_slow = 1;
        measure_gap(18, 0, "R7");
        xfer(4'b0011, 0, 4'hB, 2'd2, "R7");
        tick_slow = 0;

        // R10 start during active dropped, start in gap latched
        cfgw(8'd0, 4'h0, 1, 0, 0, 0);
        cur_req = "R10";
        @(negedge clk); req_start = 1; req_code = 4'h0;
        @(negedge clk); req_start = 0;
        wait_event();
        @(negedge clk); req_start = 1; req_code = 4'b0001;
        @(negedge clk); req_start = 0;
        @(negedge clk); req_end = 1;
        @(negedge clk); req_end = 0;
        dn = 0;
        for (int k = 0; k < 40; k++) begin
            @(negedge clk);
            if (sel_done) dn++;
        end
        chk("R10", "dropped start", 8'(dn), 8'd0);
        @(negedge clk); req_start = 1; req_code = 4'b0000;
        @(negedge clk); req_end = 1; req_start = 0;
        @(negedge clk); req_end = 0;
        // now in gap: new start latched with code 1101, then code changes
        @(negedge clk); req_start = 1; req_code = 4'b1101;
        @(negedge clk); req_start = 0; req_code = 4'b0000;
        wait_event();
        chk("R10", "held start served", {7'h0, sel_done}, 8'h1);
        chk("R8", "latched code", {4'h0, sel_lines}, 8'h0D);
        release_sel("R11");

        repeat (5) @(negedge clk);
        report();
        $finish;
    end

endmodule